// File: doc/BRIEF.md
# GPIO Command Source Arbiter

This block holds the GPIO control registers of a set of 32-pin banks and decides, for every 8-pin group, which of three bus masters may change them: the host CPU, an LPC bus master or an embedded coprocessor. Each group has a 2-bit owner code. Bit 0 of the code sits in the bank's "owner-low" register and bit 1 in its "owner-high" register. A write to the output-data, output-enable, interrupt-enable or reset-tolerance register of a bank changes only the bytes of groups that the writing master owns. Bytes of the other groups in the same word keep their old value.

Only the host CPU can write the owner registers. To hand a group over, the host writes the owner-high word first and the owner-low word after it. Code 3 is reserved. A group that holds code 3 accepts writes from no master and raises its error flag until its code changes. The debounce-select register is not gated, so any master may write it. The read port has no master input and returns every register unchanged.

Top module: `gpio_csa_top`

## Requirements
- R1: After reset, every control register and owner register is zero, so every group belongs to the host CPU (code 0), and every error flag is low.
- R2: Group g (0..3) of a bank takes code bit 0 from bit 8*g of owner-low (address kind 5) and code bit 1 from bit 8*g of owner-high (kind 6). Codes: 0 = host CPU, 1 = LPC, 2 = coprocessor, 3 = reserved. When the owner registers are read, every other bit returns 0.
- R3: A write to output-data (kind 0), output-enable (kind 1), interrupt-enable (kind 2) or reset-tolerance (kind 3) updates only the bytes of groups whose code equals the writing master's code. All other bytes of the word are left as they were.
- R4: A write to an owner register from any master other than the host CPU has no effect.
- R5: Debounce-select (kind 4) takes the full written word from any master, whatever the group codes are.
- R6: While a group holds code 3, writes to its byte from every master are dropped and its bit of grp_err is 1. The bit returns to 0 as soon as the code changes.
- R7: rd_data shows the addressed register (address = {bank, kind[2:0]}) in the same cycle, with no dependence on any master. Kind 7 and out-of-range banks read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Write strobe |
| wr_master | input | 2 | Code of the master issuing the write |
| wr_addr | input | ADDR_W | Write address {bank, kind} |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read address {bank, kind} |
| rd_data | output | 32 | Read data |
| gpio_dout | output | 32*NUM_BANKS | Output-data registers of all banks |
| gpio_oe | output | 32*NUM_BANKS | Output-enable registers |
| irq_en | output | 32*NUM_BANKS | Interrupt-enable registers |
| tol_en | output | 32*NUM_BANKS | Reset-tolerance registers |
| dbnc_sel | output | 32*NUM_BANKS | Debounce-select registers |
| grp_err | output | 4*NUM_BANKS | Per-group flag for the reserved code |

## Verification
A write presented before a rising edge is stored at that edge. Its effect appears on the register outputs, on rd_data and, for owner writes, on grp_err before the next edge. rd_data is combinational from the stored registers. The bench drives each write at a falling edge and releases it at the following falling edge, so every check samples half a period after the capturing edge. Reads set rd_addr and sample after a short settle delay, with no clock edge in between.

// File: rtl/gpio_csa_pkg.sv
package gpio_csa_pkg;
  typedef enum logic [1:0] {
    SRC_HOST  = 2'd0,
    SRC_LPC   = 2'd1,
    SRC_COPRO = 2'd2,
    SRC_RSVD  = 2'd3
  } src_code_e;

  typedef enum logic [2:0] {
    K_DOUT = 3'd0,
    K_OE   = 3'd1,
    K_IEN  = 3'd2,
    K_TOL  = 3'd3,
    K_DBNC = 3'd4,
    K_SRC0 = 3'd5,
    K_SRC1 = 3'd6,
    K_NONE = 3'd7
  } reg_kind_e;

  localparam int GRP_PER_BANK = 4;
  localparam int GRP_BITS     = 8;
  localparam int WORD_W       = GRP_PER_BANK * GRP_BITS;
endpackage

// File: rtl/gpio_csa_owner.sv
module gpio_csa_owner
  import gpio_csa_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 1,
  localparam int NG       = NUM_BANKS * GRP_PER_BANK
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_master,
  input  logic [BANK_W-1:0] wr_bank,
  input  reg_kind_e         wr_kind,
  input  logic [GRP_PER_BANK-1:0] wr_bits,
  output logic [NG-1:0]     src0_q,
  output logic [NG-1:0]     src1_q,
  output logic [2*NG-1:0]   grp_code,
  output logic [NG-1:0]     grp_err
);
  logic [NG-1:0] src0_d, src1_d;
  logic          src0_we, src1_we;
  logic          bank_ok, host_wr;

  always_comb begin
    bank_ok = int'(wr_bank) < NUM_BANKS;
    host_wr = wr_en && (wr_master == SRC_HOST) && bank_ok;
    src0_we = host_wr && (wr_kind == K_SRC0);
    src1_we = host_wr && (wr_kind == K_SRC1);
    src0_d  = src0_q;
    src1_d  = src1_q;
    if (bank_ok) begin
      src0_d[int'(wr_bank)*GRP_PER_BANK +: GRP_PER_BANK] = wr_bits;
      src1_d[int'(wr_bank)*GRP_PER_BANK +: GRP_PER_BANK] = wr_bits;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src0_q <= '0;
      src1_q <= '0;
    end else begin
      if (src0_we) src0_q <= src0_d;
      if (src1_we) src1_q <= src1_d;
    end
  end

  for (genvar i = 0; i < NG; i++) begin : g_code
    assign grp_code[2*i +: 2] = {src1_q[i], src0_q[i]};
    assign grp_err[i]         = src1_q[i] & src0_q[i];
  end

  // R4: owner registers ignore every master except the host CPU
  assert_owner_host_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_master != SRC_HOST) |=> ($stable(src0_q) && $stable(src1_q)));
endmodule

// File: rtl/gpio_csa_mask.sv
module gpio_csa_mask
  import gpio_csa_pkg::*;
#(
  parameter int NG = 8
) (
  input  logic [2*NG-1:0] grp_code,
  input  logic [1:0]      wr_master,
  output logic [NG-1:0]   grp_allow
);
  for (genvar i = 0; i < NG; i++) begin : g_allow
    assign grp_allow[i] = (grp_code[2*i +: 2] == wr_master) &&
                          (grp_code[2*i +: 2] != SRC_RSVD);
  end
endmodule

// File: rtl/gpio_csa_bank.sv
module gpio_csa_bank
  import gpio_csa_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_sel,
  input  reg_kind_e               wr_kind,
  input  logic [WORD_W-1:0]       wr_data,
  input  logic [GRP_PER_BANK-1:0] grp_allow,
  output logic [WORD_W-1:0]       dout_q,
  output logic [WORD_W-1:0]       oe_q,
  output logic [WORD_W-1:0]       ien_q,
  output logic [WORD_W-1:0]       tol_q,
  output logic [WORD_W-1:0]       dbnc_q
);
  logic [WORD_W-1:0] bmask;
  logic [WORD_W-1:0] dout_d, oe_d, ien_d, tol_d, dbnc_d;
  logic              dout_we, oe_we, ien_we, tol_we, dbnc_we;

  always_comb begin
    for (int g = 0; g < GRP_PER_BANK; g++)
      bmask[g*GRP_BITS +: GRP_BITS] = {GRP_BITS{grp_allow[g]}};
    dout_we = wr_sel && (wr_kind == K_DOUT);
    oe_we   = wr_sel && (wr_kind == K_OE);
    ien_we  = wr_sel && (wr_kind == K_IEN);
    tol_we  = wr_sel && (wr_kind == K_TOL);
    dbnc_we = wr_sel && (wr_kind == K_DBNC);
    dout_d  = (dout_q & ~bmask) | (wr_data & bmask);
    oe_d    = (oe_q   & ~bmask) | (wr_data & bmask);
    ien_d   = (ien_q  & ~bmask) | (wr_data & bmask);
    tol_d   = (tol_q  & ~bmask) | (wr_data & bmask);
    dbnc_d  = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      oe_q   <= '0;
      ien_q  <= '0;
      tol_q  <= '0;
      dbnc_q <= '0;
    end else begin
      if (dout_we) dout_q <= dout_d;
      if (oe_we)   oe_q   <= oe_d;
      if (ien_we)  ien_q  <= ien_d;
      if (tol_we)  tol_q  <= tol_d;
      if (dbnc_we) dbnc_q <= dbnc_d;
    end
  end

  for (genvar g = 0; g < GRP_PER_BANK; g++) begin : g_chk
    // R3: a byte whose group the writer does not own keeps its value
    assert_nonowner_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sel && wr_kind == K_DOUT && !grp_allow[g]) |=>
        $stable(dout_q[g*GRP_BITS +: GRP_BITS]));
  end

  // R5: debounce select takes the whole word from any master
  assert_dbnc_ungated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel && wr_kind == K_DBNC) |=> (dbnc_q == $past(wr_data)));
endmodule

// File: rtl/gpio_csa_top.sv
module gpio_csa_top
  import gpio_csa_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W   = BANK_W + 3,
  localparam int NG       = NUM_BANKS * GRP_PER_BANK,
  localparam int FLAT_W   = NUM_BANKS * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_master,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic [FLAT_W-1:0] gpio_dout,
  output logic [FLAT_W-1:0] gpio_oe,
  output logic [FLAT_W-1:0] irq_en,
  output logic [FLAT_W-1:0] tol_en,
  output logic [FLAT_W-1:0] dbnc_sel,
  output logic [NG-1:0]     grp_err
);
  logic [1:0]              rst_sync;
  logic                    rst_in_n;
  logic [BANK_W-1:0]       wr_bank, rd_bank;
  reg_kind_e               wr_kind, rd_kind;
  logic [GRP_PER_BANK-1:0] wr_bits;
  logic [NG-1:0]           src0_q, src1_q, grp_allow;
  logic [2*NG-1:0]         grp_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_in_n = rst_sync[1];

  assign wr_bank = wr_addr[ADDR_W-1:3];
  assign wr_kind = reg_kind_e'(wr_addr[2:0]);
  assign rd_bank = rd_addr[ADDR_W-1:3];
  assign rd_kind = reg_kind_e'(rd_addr[2:0]);

  for (genvar g = 0; g < GRP_PER_BANK; g++) begin : g_bits
    assign wr_bits[g] = wr_data[g*GRP_BITS];
  end

  gpio_csa_owner #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_owner (
    .clk(clk), .rst_n(rst_in_n), .wr_en(wr_en), .wr_master(wr_master),
    .wr_bank(wr_bank), .wr_kind(wr_kind), .wr_bits(wr_bits),
    .src0_q(src0_q), .src1_q(src1_q), .grp_code(grp_code), .grp_err(grp_err)
  );

  gpio_csa_mask #(.NG(NG)) u_mask (
    .grp_code(grp_code), .wr_master(wr_master), .grp_allow(grp_allow)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic bank_sel;
    assign bank_sel = wr_en && (int'(wr_bank) == b);
    gpio_csa_bank u_bank (
      .clk(clk), .rst_n(rst_in_n), .wr_sel(bank_sel), .wr_kind(wr_kind),
      .wr_data(wr_data), .grp_allow(grp_allow[b*GRP_PER_BANK +: GRP_PER_BANK]),
      .dout_q(gpio_dout[b*WORD_W +: WORD_W]), .oe_q(gpio_oe[b*WORD_W +: WORD_W]),
      .ien_q(irq_en[b*WORD_W +: WORD_W]), .tol_q(tol_en[b*WORD_W +: WORD_W]),
      .dbnc_q(dbnc_sel[b*WORD_W +: WORD_W])
    );
  end

  always_comb begin
    rd_data = '0;
    if (int'(rd_bank) < NUM_BANKS) begin
      case (rd_kind)
        K_DOUT: rd_data = gpio_dout[int'(rd_bank)*WORD_W +: WORD_W];
        K_OE:   rd_data = gpio_oe[int'(rd_bank)*WORD_W +: WORD_W];
        K_IEN:  rd_data = irq_en[int'(rd_bank)*WORD_W +: WORD_W];
        K_TOL:  rd_data = tol_en[int'(rd_bank)*WORD_W +: WORD_W];
        K_DBNC: rd_data = dbnc_sel[int'(rd_bank)*WORD_W +: WORD_W];
        K_SRC0: for (int g = 0; g < GRP_PER_BANK; g++)
                  rd_data[g*GRP_BITS] = src0_q[int'(rd_bank)*GRP_PER_BANK + g];
        K_SRC1: for (int g = 0; g < GRP_PER_BANK; g++)
                  rd_data[g*GRP_BITS] = src1_q[int'(rd_bank)*GRP_PER_BANK + g];
        default: rd_data = '0;
      endcase
    end
  end

  for (genvar i = 0; i < NG; i++) begin : g_err_chk
    // R6: a group holding the reserved code accepts no write from any master
    assert_rsvd_blocks_R6: assert property (@(posedge clk) disable iff (!rst_in_n)
      grp_err[i] |=> ($stable(gpio_dout[i*GRP_BITS +: GRP_BITS]) &&
                      $stable(gpio_oe[i*GRP_BITS +: GRP_BITS]) &&
                      $stable(irq_en[i*GRP_BITS +: GRP_BITS]) &&
                      $stable(tol_en[i*GRP_BITS +: GRP_BITS])));
  end

  // R2: owner words read back only the code bits
  assert_src_read_bits_R2: assert property (@(posedge clk) disable iff (!rst_in_n)
    (rd_kind == K_SRC0 || rd_kind == K_SRC1) |->
      ((rd_data & ~32'h0101_0101) == 32'h0));
endmodule

// File: tb/sim_gpio_csa_top.sv
module sim_gpio_csa_top;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 4;

  logic              clk, rst_n, wr_en;
  logic [1:0]        wr_master;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [31:0]       wr_data, rd_data;
  logic [63:0]       gpio_dout, gpio_oe, irq_en, tol_en, dbnc_sel;
  logic [7:0]        grp_err;
  int total = 0;
  int bad   = 0;
  bit done  = 0;

  gpio_csa_top u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_master(wr_master),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .gpio_dout(gpio_dout), .gpio_oe(gpio_oe), .irq_en(irq_en),
    .tol_en(tol_en), .dbnc_sel(dbnc_sel), .grp_err(grp_err)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] m, input int bank, input int kind, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_master = m; wr_addr = ADDR_W'(bank*8 + kind); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int bank, input int kind, output logic [31:0] v);
    rd_addr = ADDR_W'(bank*8 + kind);
    #1;
    v = rd_data;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 dout", gpio_dout, 64'h0);
    chk("R1 oe", gpio_oe, 64'h0);
    chk("R1 err", {56'h0, grp_err}, 64'h0);
    rd(0, 5, v); chk("R1 src0", {32'h0, v}, 64'h0);
    rd(1, 6, v); chk("R1 src1", {32'h0, v}, 64'h0);
  endtask

  task automatic t_owner_basic;
    logic [31:0] v;
    wr(2'd0, 0, 0, 32'hA5A5_A5A5);
    chk("R3 host write", gpio_dout[31:0], 64'hA5A5_A5A5);
    wr(2'd1, 0, 0, 32'hFFFF_FFFF);
    chk("R3 lpc dropped", gpio_dout[31:0], 64'hA5A5_A5A5);
    wr(2'd0, 0, 5, 32'h0000_0100);
    rd(0, 5, v); chk("R2 src0 group1", {32'h0, v}, 64'h100);
    wr(2'd1, 0, 5, 32'h0);
    rd(0, 5, v); chk("R4 lpc src write", {32'h0, v}, 64'h100);
    wr(2'd2, 0, 6, 32'hFFFF_FFFF);
    rd(0, 6, v); chk("R4 copro src write", {32'h0, v}, 64'h0);
    wr(2'd1, 0, 0, 32'h1122_3344);
    chk("R3 lpc byte1 only", gpio_dout[31:0], 64'hA5A5_33A5);
    wr(2'd0, 0, 0, 32'h0);
    chk("R3 host skips byte1", gpio_dout[31:0], 64'h0000_3300);
  endtask

  task automatic t_bank1;
    logic [31:0] v;
    wr(2'd0, 1, 5, 32'hFFFF_FFFF);
    rd(1, 5, v); chk("R2 only code bits", {32'h0, v}, 64'h0101_0101);
    wr(2'd0, 1, 1, 32'hFFFF_FFFF);
    chk("R3 host blocked bank1", gpio_oe[63:32], 64'h0);
    wr(2'd1, 1, 1, 32'h0000_FFFF);
    chk("R3 lpc bank1", gpio_oe[63:32], 64'h0000_FFFF);
    chk("R3 bank0 oe untouched", gpio_oe[31:0], 64'h0);
    wr(2'd0, 1, 5, 32'h0);
    wr(2'd2, 1, 4, 32'hDEAD_BEEF);
    chk("R5 copro debounce", dbnc_sel[63:32], 64'hDEAD_BEEF);
    rd(1, 4, v); chk("R7 read debounce", {32'h0, v}, 64'hDEAD_BEEF);
  endtask

  task automatic t_reserved;
    logic [31:0] v;
    wr(2'd0, 0, 6, 32'h0100_0000);
    chk("R6 code2 no err", {56'h0, grp_err}, 64'h0);
    wr(2'd0, 0, 5, 32'h0100_0100);
    chk("R6 err raised", {56'h0, grp_err}, 64'h08);
    wr(2'd0, 0, 1, 32'hFFFF_FFFF);
    chk("R6 host blocked byte3", gpio_oe[31:0], 64'h00FF_00FF);
    wr(2'd2, 0, 1, 32'hFF00_0000);
    chk("R6 copro blocked byte3", gpio_oe[31:0], 64'h00FF_00FF);
    wr(2'd0, 0, 5, 32'h0000_0100);
    chk("R6 err cleared", {56'h0, grp_err}, 64'h0);
    wr(2'd2, 0, 1, 32'hFF00_0000);
    chk("R3 copro owns byte3", gpio_oe[31:0], 64'hFFFF_00FF);
    wr(2'd0, 0, 3, 32'h0F0F_0F0F);
    chk("R3 tol host bytes", tol_en[31:0], 64'h000F_000F);
    rd(0, 3, v); chk("R7 read tol", {32'h0, v}, 64'h000F_000F);
    rd(0, 7, v); chk("R7 kind7 zero", {32'h0, v}, 64'h0);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_master = 2'd0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_owner_basic();
    t_bank1();
    t_reserved();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P*20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule